// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This unit turns an intermediate floating-point value into a finished IEEE-754 binary32 word. The value arrives as a sign, a 16-bit signed exponent that is one below the true biased exponent, and a 32-bit significand. Bit 30 of the significand is the leading one and bits 6:0 are seven guard bits below the final fraction. The unit rounds in one of four modes and detects overflow and tininess. It denormalises tiny values with a sticky right shift and can flush them to signed zero. Beside the packed word it returns four status flags. Requests can set a normalise option: the significand is then shifted left until its leading one reaches bit 30, and the exponent is lowered by the same amount before rounding.

Operands enter through a valid/ready port and results leave through a second valid/ready port behind one register stage. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or being drained in the same cycle, so full throughput needs no bubbles. A result stays on the output, unchanged, until `out_ready` takes it. The rounding mode, the two mask bits and the flush control are plain pins, sampled together with the operand.

Top module: `rp_unit`

## Requirements
- R1: An operand accepted on an edge (`in_valid` and `in_ready` high) produces `out_valid` high after that edge. `in_ready` is low exactly while a result is held with `out_ready` low, and a held result and its flags stay stable until it is taken.
- R2: Rounding mode encoding: 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero. The value added below the guard bits is 0x40 for mode 0, 0 for mode 3, and 0x7F in the direction away from zero (mode 2 on positive, mode 1 on negative), otherwise 0. The result is {sign, exponent, fraction}, where the fraction is (significand + increment) >> 7 and its carry reaches the exponent by addition.
- R3: In nearest-even mode, when the guard bits equal exactly 0x40 the result LSB is cleared.
- R4: Overflow (flag bit 0) occurs when the exponent input is above 0xFD, or equals 0xFD and significand + increment sets bit 31. The result is then infinity (exponent 0xFF, fraction 0), or the largest finite value of that sign when the increment is zero.
- R5: On overflow, inexact (flag bit 2) is set when the guard bits are nonzero or the overflow mask input is high. Rounded-up (flag bit 3) is set when inexact is set and the increment is nonzero.
- R6: A negative exponent input is tiny when it is below -1, or when significand + increment is below 0x80000000, both judged before any shift. The significand is shifted right by the negated exponent, with any lost one ORed into bit 0, and the exponent becomes 0.
- R7: Underflow (flag bit 1) is set for a tiny value when its post-shift guard bits are nonzero or the underflow mask input is low. Overflow and underflow are never set together.
- R8: With the flush input high, an underflowing value gives signed zero with underflow and inexact set and rounded-up clear.
- R9: Outside overflow and flush, inexact is set when the (post-shift) guard bits are nonzero, and rounded-up is set when the rounded fraction shifted left by 7 exceeds the pre-round significand. A rounded fraction of zero forces exponent 0.
- R10: With the normalise input high, the significand is shifted left by its leading-zero count minus one (not at all when bit 31 is set), and the exponent drops by the same amount before rounding. Otherwise bit 31 of the significand is expected to be zero.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 16 | Signed exponent, true biased exponent minus one |
| in_sig | input | 32 | Significand, leading one at bit 30, 7 guard bits |
| in_normalize | input | 1 | Pre-normalise the significand before rounding |
| rnd_mode | input | 2 | Rounding mode (R2 encoding) |
| ovf_masked | input | 1 | Overflow exception masked |
| unf_masked | input | 1 | Underflow exception masked |
| flush_zero | input | 1 | Flush underflowing results to zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Packed binary32 result |
| out_flags | output | 4 | {rounded-up, inexact, underflow, overflow} |

## Verification
The hardest points to reach are the narrow band at exponent -1 and the band at exponent 0xFD, where a single carry from the increment decides tininess or overflow. Random operands almost never land there. The stimulus therefore draws exponents from weighted bands around -2..1 and 0xF0..0xFF, and forces the guard bits to the tie pattern or all ones on a fraction of draws. Directed cases set significands such as 0x7FFFFFC0 so that the carry happens in one mode and not in another.

// File: rtl/rp_pkg.sv
package rp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rp_mode_e;

  // Packed LSB first from the bottom: ovf is bit 0.
  typedef struct packed {
    logic rup;
    logic inx;
    logic unf;
    logic ovf;
  } rp_flags_t;

endpackage

// File: rtl/rp_lzc.sv
module rp_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rp_normalize.sv
module rp_normalize #(
  parameter int SIG_W = 32,
  parameter int EXP_W = 16
) (
  input  logic                    enable,
  input  logic [SIG_W-1:0]        sig_in,
  input  logic signed [EXP_W-1:0] exp_in,
  output logic [SIG_W-1:0]        sig_out,
  output logic signed [EXP_W-1:0] exp_out
);
  localparam int CW = $clog2(SIG_W + 1);

  logic [CW-1:0] lz;
  logic [CW-1:0] shamt;

  rp_lzc #(.W(SIG_W)) u_lzc (
    .vec   (sig_in),
    .count (lz)
  );

  always_comb begin
    shamt = (lz == '0) ? '0 : lz - CW'(1);
    if (enable) begin
      sig_out = sig_in << shamt;
      exp_out = exp_in - EXP_W'(shamt);
    end else begin
      sig_out = sig_in;
      exp_out = exp_in;
    end
  end
endmodule

// File: rtl/rp_round_core.sv
module rp_round_core
  import rp_pkg::*;
#(
  parameter int SIG_W = 32,
  parameter int GRD_W = 7,
  parameter int EXP_W = 16,
  parameter int EW    = 8,
  localparam int FW   = SIG_W - GRD_W - 2,
  localparam int RW   = 1 + EW + FW
) (
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic [SIG_W-1:0]        sig_in,
  input  rp_mode_e                mode,
  input  logic                    ovf_masked,
  input  logic                    unf_masked,
  input  logic                    flush_zero,
  output logic [RW-1:0]           result,
  output rp_flags_t               flags
);
  localparam int SHW = $clog2(SIG_W);
  localparam int RDW = SIG_W - GRD_W;
  localparam logic signed [EXP_W-1:0] MAXE  = EXP_W'((1 << EW) - 3);
  localparam logic signed [EXP_W-1:0] M_ONE = -EXP_W'(1);
  localparam logic [SIG_W-1:0] HALF  = SIG_W'(1) << (GRD_W - 1);
  localparam logic [SIG_W-1:0] GMASK = (SIG_W'(1) << GRD_W) - SIG_W'(1);
  localparam logic [GRD_W-1:0] TIE   = GRD_W'(1) << (GRD_W - 1);

  logic [SIG_W-1:0] incr, sum, shifted, sig_d, lost_mask, rsum;
  logic [EXP_W-1:0] neg_exp;
  logic [SHW-1:0]   amt;
  logic [GRD_W-1:0] rb_pre, rb;
  logic [RDW-1:0]   rounded;
  logic [EW-1:0]    exp_d;
  logic             ovf_hit, tiny_path, tiny, unf_hit, big_shift;
  logic [RW-1:0]    inf_word, norm_word;

  // Increment chosen from mode and sign.
  always_comb begin
    unique case (mode)
      RM_NEAR: incr = HALF;
      RM_ZERO: incr = '0;
      RM_DOWN: incr = sign ? GMASK : '0;
      RM_UP:   incr = sign ? '0 : GMASK;
      default: incr = '0;
    endcase
  end

  // Range decisions, taken on the unshifted significand.
  always_comb begin
    sum       = sig_in + incr;
    rb_pre    = sig_in[GRD_W-1:0];
    ovf_hit   = (exp_in > MAXE) || ((exp_in == MAXE) && sum[SIG_W-1]);
    tiny_path = (exp_in < 0);
    tiny      = (exp_in < M_ONE) || !sum[SIG_W-1];
  end

  // Sticky right shift for the tiny range.
  always_comb begin
    neg_exp   = -exp_in;
    big_shift = (neg_exp >= EXP_W'(SIG_W));
    amt       = neg_exp[SHW-1:0];
    lost_mask = ~({SIG_W{1'b1}} << amt);
    if (big_shift)
      shifted = {{(SIG_W-1){1'b0}}, |sig_in};
    else
      shifted = (sig_in >> amt) | {{(SIG_W-1){1'b0}}, |(sig_in & lost_mask)};
    sig_d   = tiny_path ? shifted : sig_in;
    rb      = sig_d[GRD_W-1:0];
    unf_hit = tiny_path && tiny && ((rb != '0) || !unf_masked);
  end

  // Rounding and packing; the fraction carry propagates into the exponent.
  always_comb begin
    rsum    = sig_d + incr;
    rounded = rsum[SIG_W-1:GRD_W];
    if ((mode == RM_NEAR) && (rb == TIE))
      rounded[0] = 1'b0;
    exp_d = tiny_path ? '0 : exp_in[EW-1:0];
    if (rounded == '0)
      exp_d = '0;
    norm_word = {sign, {(RW-1){1'b0}}} + {1'b0, exp_d, {FW{1'b0}}} + RW'(rounded);
    inf_word  = {sign, {EW{1'b1}}, {FW{1'b0}}};
  end

  // Output selection.
  always_comb begin
    flags = '0;
    if (ovf_hit) begin
      flags.ovf = 1'b1;
      flags.inx = (rb_pre != '0) || ovf_masked;
      flags.rup = flags.inx && (incr != '0);
      result    = inf_word - ((incr == '0) ? RW'(1) : RW'(0));
    end else if (unf_hit && flush_zero) begin
      flags.unf = 1'b1;
      flags.inx = 1'b1;
      result    = {sign, {(RW-1){1'b0}}};
    end else begin
      flags.unf = unf_hit;
      flags.inx = (rb != '0);
      flags.rup = ({rounded, {GRD_W{1'b0}}} > sig_d);
      result    = norm_word;
    end
  end
endmodule

// File: rtl/rp_unit.sv
module rp_unit
  import rp_pkg::*;
#(
  parameter int SIG_W = 32,
  parameter int GRD_W = 7,
  parameter int EXP_W = 16,
  parameter int EW    = 8,
  localparam int FW   = SIG_W - GRD_W - 2,
  localparam int RW   = 1 + EW + FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0] in_sig,
  input  logic             in_normalize,
  input  logic [1:0]       rnd_mode,
  input  logic             ovf_masked,
  input  logic             unf_masked,
  input  logic             flush_zero,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RW-1:0]    out_result,
  output logic [3:0]       out_flags
);
  logic                    accept;
  logic [SIG_W-1:0]        n_sig;
  logic signed [EXP_W-1:0] n_exp;
  logic [RW-1:0]           c_result;
  rp_flags_t               c_flags;

  rp_normalize #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_norm (
    .enable  (in_normalize),
    .sig_in  (in_sig),
    .exp_in  ($signed(in_exp)),
    .sig_out (n_sig),
    .exp_out (n_exp)
  );

  rp_round_core #(.SIG_W(SIG_W), .GRD_W(GRD_W), .EXP_W(EXP_W), .EW(EW)) u_core (
    .sign       (in_sign),
    .exp_in     (n_exp),
    .sig_in     (n_sig),
    .mode       (rp_mode_e'(rnd_mode)),
    .ovf_masked (ovf_masked),
    .unf_masked (unf_masked),
    .flush_zero (flush_zero),
    .result     (c_result),
    .flags      (c_flags)
  );

  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= c_result;
      out_flags  <= c_flags;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/rp_unit_chk.sv
module rp_unit_chk #(
  parameter int EW = 8,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_result,
  input logic [3:0]    out_flags
);
  localparam logic [EW-1:0] EXP_BIG = {{(EW-1){1'b1}}, 1'b0};
  localparam logic [EW-1:0] EXP_ONE = EW'(1);

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags));

  p_ovf_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[0] |-> out_result[RW-2 -: EW] >= EXP_BIG);

  p_unf_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[1] |-> out_result[RW-2 -: EW] <= EXP_ONE);

  p_no_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flags[0] && out_flags[1]));

  p_rup_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[3] |-> out_flags[2]);
endmodule

bind rp_unit rp_unit_chk #(.EW(EW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/test_rp_unit.sv
module test_rp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [31:0] in_sig = '0;
  logic        in_normalize = 1'b0;
  logic [1:0]  rnd_mode = 2'd0;
  logic        ovf_masked = 1'b0;
  logic        unf_masked = 1'b0;
  logic        flush_zero = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [3:0]  out_flags;

  int checks = 0;
  int errs = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rp_unit i_rp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_normalize(in_normalize),
    .rnd_mode(rnd_mode), .ovf_masked(ovf_masked), .unf_masked(unf_masked),
    .flush_zero(flush_zero), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  // Reference model built from the requirements: {flags[3:0], result[31:0]}.
  function automatic logic [35:0] ref_model(input logic s, input logic [15:0] e_in,
      input logic [31:0] m_in, input logic nrm, input logic [1:0] md,
      input logic om, input logic um, input logic fz);
    int e, lz, sh, inc, rb, amt;
    longint m, sm, r;
    logic [15:0] et;
    logic tiny, unf, ix, rup;
    logic [31:0] res;
    e = int'($signed(e_in));
    m = longint'(m_in);
    unf = 1'b0;
    if (nrm) begin                          // R10
      lz = 32;
      for (int i = 0; i < 32; i++) if (m_in[i]) lz = 31 - i;
      sh = (lz == 0) ? 0 : lz - 1;
      m = (m << sh) & 64'hFFFF_FFFF;
      et = 16'(e - sh);
      e = int'($signed(et));
    end
    case (md)                               // R2
      2'd0: inc = 64;
      2'd3: inc = 0;
      2'd1: inc = s ? 127 : 0;
      default: inc = s ? 0 : 127;
    endcase
    rb = int'(m & 127);
    sm = (m + longint'(inc)) & 64'hFFFF_FFFF;
    if (e > 253 || (e == 253 && sm >= 64'h8000_0000)) begin   // R4, R5
      ix  = (rb != 0) || om;
      rup = ix && (inc != 0);
      res = {s, 8'hFF, 23'd0} - ((inc == 0) ? 32'd1 : 32'd0);
      return {rup, ix, 1'b0, 1'b1, res};
    end
    if (e < 0) begin                        // R6, R7, R8
      tiny = (e < -1) || (sm < 64'h8000_0000);
      amt = -e;
      if (amt >= 32) m = (m != 0) ? 64'd1 : 64'd0;
      else m = (m >> amt) | (((m & ((64'd1 << amt) - 1)) != 0) ? 64'd1 : 64'd0);
      e = 0;
      rb = int'(m & 127);
      if (tiny && (rb != 0 || !um)) begin
        unf = 1'b1;
        if (fz) return {1'b0, 1'b1, 1'b1, 1'b0, s, 31'd0};
      end
    end
    ix = (rb != 0);                         // R9
    r = (m + longint'(inc)) >> 7;
    if (md == 2'd0 && rb == 64) r = r & ~64'd1;   // R3
    rup = ((r << 7) > m);
    if (r == 0) e = 0;
    res = 32'((longint'(s) << 31) + (longint'(e) << 23) + r);
    return {rup, ix, unf, 1'b0, res};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [15:0] e, input logic [31:0] m,
      input logic nrm, input logic [1:0] md, input logic om, input logic um, input logic fz);
    in_sign = s; in_exp = e; in_sig = m; in_normalize = nrm;
    rnd_mode = md; ovf_masked = om; unf_masked = um; flush_zero = fz;
  endtask

  // One transfer with out_ready high; the result is visible one edge later.
  task automatic run_one(input string req, input logic s, input logic [15:0] e,
      input logic [31:0] m, input logic nrm, input logic [1:0] md,
      input logic om, input logic um, input logic fz);
    @(negedge clk);
    drive(s, e, m, nrm, md, om, um, fz);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {35'd0, out_valid}, 36'd1);
    check(req, {out_flags, out_result}, ref_model(s, e, m, nrm, md, om, um, fz));
  endtask

  task automatic run_fixed(input string req, input logic s, input logic [15:0] e,
      input logic [31:0] m, input logic [1:0] md, input logic om, input logic um,
      input logic fz, input logic [35:0] want);
    @(negedge clk);
    drive(s, e, m, 1'b0, md, om, um, fz);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_flags, out_result}, want);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [35:0] exp_a, exp_b;
    void'($urandom(32'd20240611));
    #3;
    check("R11 out_valid after reset", {35'd0, out_valid}, 36'd0);
    check("R11 in_ready after reset", {35'd0, in_ready}, 36'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2: same operand in all four modes, both signs
    for (int md = 0; md < 4; md++) begin
      run_one("R2 mode pos", 1'b0, 16'd126, 32'h4000_0041, 1'b0, 2'(md), 1'b1, 1'b1, 1'b0);
      run_one("R2 mode neg", 1'b1, 16'd126, 32'h4000_0041, 1'b0, 2'(md), 1'b1, 1'b1, 1'b0);
    end
    // R3: ties, even and odd
    run_fixed("R3 tie even", 1'b0, 16'd126, 32'h4000_0040, 2'd0, 1'b1, 1'b1, 1'b0,
              {4'b0100, 32'h3F80_0000});
    run_fixed("R3 tie odd", 1'b0, 16'd126, 32'h4000_00C0, 2'd0, 1'b1, 1'b1, 1'b0,
              {4'b1100, 32'h3F80_0002});
    // R4: carry into overflow at 0xFD, and directed saturation
    run_fixed("R4 carry to inf", 1'b0, 16'h00FD, 32'h7FFF_FFC0, 2'd0, 1'b1, 1'b1, 1'b0,
              {4'b1101, 32'h7F80_0000});
    run_fixed("R4 toward zero max", 1'b0, 16'h00FE, 32'h4000_0000, 2'd3, 1'b0, 1'b1, 1'b0,
              {4'b0001, 32'h7F7F_FFFF});
    run_one("R4 no carry at 0xFD", 1'b0, 16'h00FD, 32'h7FFF_FFC0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0);
    run_one("R4 neg down", 1'b1, 16'h0120, 32'h4000_0000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    // R5: mask decides inexact on exact overflow
    run_one("R5 masked", 1'b0, 16'h00FE, 32'h4000_0000, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    run_one("R5 unmasked", 1'b0, 16'h00FE, 32'h4000_0000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    // R6: tininess at exponent -1 before rounding
    run_one("R6 not tiny -1", 1'b0, 16'hFFFF, 32'h7FFF_FFC0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    run_one("R6 tiny -1", 1'b0, 16'hFFFF, 32'h7FFF_FF00, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    run_one("R6 deep shift", 1'b1, 16'hFF9C, 32'h4000_0001, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);
    // R7: exact tiny value flagged only when unmasked
    run_one("R7 exact unmasked", 1'b0, 16'hFFFE, 32'h4000_0000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    run_one("R7 exact masked", 1'b0, 16'hFFFE, 32'h4000_0000, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    // R8: flush to signed zero
    run_fixed("R8 flush neg", 1'b1, 16'hFFFB, 32'h4000_0001, 2'd0, 1'b1, 1'b1, 1'b1,
              {4'b0110, 32'h8000_0000});
    // R9: zero significand gives zero word
    run_fixed("R9 zero", 1'b0, 16'd90, 32'h0000_0000, 2'd2, 1'b1, 1'b1, 1'b0,
              {4'b0000, 32'h0000_0000});
    // R10: normalise option
    run_one("R10 normalise", 1'b0, 16'd20, 32'h0000_1234, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
    run_one("R10 normalise to tiny", 1'b1, 16'd3, 32'h0000_00FF, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0);

    // R1: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b0, 16'd127, 32'h4800_0000, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    exp_a = ref_model(1'b0, 16'd127, 32'h4800_0000, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    drive(1'b1, 16'd130, 32'h5000_0011, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);
    exp_b = ref_model(1'b1, 16'd130, 32'h5000_0011, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);
    check("R1 in_ready low when stalled", {35'd0, in_ready}, 36'd0);
    @(negedge clk);
    check("R1 held result", {out_flags, out_result}, exp_a);
    check("R1 held valid", {35'd0, out_valid}, 36'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second result", {out_flags, out_result}, exp_b);
    @(negedge clk);
    check("R1 drained", {35'd0, out_valid}, 36'd0);

    // Random operands (R2 and the range rules)
    for (int n = 0; n < 600; n++) begin
      logic s, nrm, om, um, fz;
      logic [1:0] md;
      logic [15:0] e;
      logic [31:0] m;
      int band;
      s = 1'($urandom); md = 2'($urandom); om = 1'($urandom);
      um = 1'($urandom); fz = 1'($urandom);
      nrm = (($urandom % 4) == 0);
      band = $urandom % 6;
      case (band)
        0: e = 16'(-1 - int'($urandom % 40));
        1: e = 16'($urandom % 21);
        2: e = 16'(240 + ($urandom % 16));
        3: e = 16'(100 + ($urandom % 31));
        4: e = 16'(int'($urandom % 4) - 2);
        default: e = 16'($urandom);
      endcase
      if (nrm) m = $urandom >> ($urandom % 32);
      else m = {2'b01, 30'($urandom)};
      m[31] = 1'b0;
      case ($urandom % 4)
        0: m[6:0] = 7'h40;
        1: m[6:0] = 7'h7F;
        default: ;
      endcase
      run_one("R2 random", s, e, m, nrm, md, om, um, fz);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule